// File: doc/BRIEF.md
# Bidirectional Rolling-Shutter Readout Sequencer

This block sequences frame readout for a pixel array whose words are delivered in parallel per column and sent off chip bit-serially. The array is split into an upper and a lower half. Both halves are scanned at the same time, one row per slot. The scan starts at the two rows on either side of the array's centre line. From there the upper half moves toward the top edge and the lower half toward the bottom edge. Every column owns two serializers, one per half, and all of them shift in lockstep, most significant bit first.

Two mask registers pick out a region of interest. The row mask decides which rows are serialized; a row pair whose two rows are both deselected takes no time at all. The column mask decides which columns drive their serial lines. Software loads both masks through a small word-wide write port while the sequencer is idle. A single start strobe launches a frame, and a one-cycle done strobe closes it.

Top module: `rs_readout_seq`

## Requirements
- R1: After reset all serial outputs, both word-valid strobes and the done strobe are low, and every bit of both masks is 1 (all rows and columns selected).
- R2: Each serialized word is WBITS bits long and is sent most significant bit first, one bit per cycle. The upper half sends the word presented on pix_up_i for row row_up_o, and the lower half sends the word on pix_dn_i for row row_dn_o.
- R3: Pair k (k = 0 .. NROWS/2-1) is made of upper row NROWS/2-1-k and lower row NROWS/2+k, and pairs are visited in increasing k. The row outputs name the pair about to be loaded. Its words are captured on the last cycle before its slot: the single fill cycle after start, or the last bit cycle of the previous slot.
- R4: A pair whose two row-mask bits are both 0 takes no cycles. With N selected pairs, the frame takes one fill cycle and then N*WBITS bit cycles.
- R5: In a pair where only one row is selected, the half whose row is deselected keeps its serial outputs and its word-valid strobe low for that slot.
- R6: A column whose column-mask bit is 0 holds both of its serial outputs low.
- R7: wvld_up_o / wvld_dn_o is high exactly on the first (MSB) bit cycle of each word sent by that half.
- R8: frame_done_o is high for exactly one cycle, the cycle after the last bit. A start with no row selected raises done in the cycle right after start.
- R9: A start strobe that arrives while a frame is in progress has no effect.
- R10: On a write, cfg_col_i = 0 targets the row mask and 1 targets the column mask. Word cfg_idx_i = k loads mask bits k*MW .. k*MW+MW-1 from cfg_data_i bits 0 .. MW-1. Writes made while a frame is in progress are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| frame_start_i | input | 1 | Frame launch strobe |
| frame_done_o | output | 1 | One-cycle end-of-frame strobe |
| cfg_wr_i | input | 1 | Mask write enable |
| cfg_col_i | input | 1 | Write target: 0 row mask, 1 column mask |
| cfg_idx_i | input | IW | Mask word index |
| cfg_data_i | input | MW | Mask word data |
| row_up_o | output | clog2(NROWS) | Upper-half row to present |
| row_dn_o | output | clog2(NROWS) | Lower-half row to present |
| pix_up_i | input | NCOLS*WBITS | Upper-half words, column c at bits c*WBITS |
| pix_dn_i | input | NCOLS*WBITS | Lower-half words, column c at bits c*WBITS |
| ser_up_o | output | NCOLS | Upper-half serial lines, one per column |
| ser_dn_o | output | NCOLS | Lower-half serial lines, one per column |
| wvld_up_o | output | 1 | Upper-half first-bit strobe |
| wvld_dn_o | output | 1 | Lower-half first-bit strobe |

## Verification
The bench builds the block with 4 columns, 8 rows (four row pairs), 5-bit words and 4-bit mask words. With these values the row mask spans two write words and the column mask one, so the index decode is exercised across words. A whole frame is only a few dozen cycles, which lets the bench compare every serial bit of every column against its own pixel model. It can also reach the corner cases quickly: one-sided pairs, skipped pairs, fully gated columns and an empty row mask.

// File: rtl/rs_pkg.sv
package rs_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_FILL = 2'd1,
        ST_RUN  = 2'd2
    } seq_st_e;
endpackage

// File: rtl/rs_mask_regs.sv
module rs_mask_regs #(
    parameter int NROWS = 128,
    parameter int NCOLS = 160,
    parameter int MW    = 16,
    parameter int IW    = 4
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             wr_i,
    input  logic             col_i,
    input  logic [IW-1:0]    idx_i,
    input  logic [MW-1:0]    data_i,
    output logic [NROWS-1:0] row_mask_o,
    output logic [NCOLS-1:0] col_mask_o
);
    logic [NROWS-1:0] row_d, row_q;
    logic [NCOLS-1:0] col_d, col_q;

    always_comb begin
        row_d = row_q;
        col_d = col_q;
        if (wr_i) begin
            for (int i = 0; i < NROWS; i++) begin
                if (!col_i && (i / MW) == int'(idx_i)) row_d[i] = data_i[i % MW];
            end
            for (int i = 0; i < NCOLS; i++) begin
                if (col_i && (i / MW) == int'(idx_i)) col_d[i] = data_i[i % MW];
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            row_q <= '1;
            col_q <= '1;
        end else begin
            row_q <= row_d;
            col_q <= col_d;
        end
    end

    assign row_mask_o = row_q;
    assign col_mask_o = col_q;
endmodule

// File: rtl/rs_pair_find.sv
module rs_pair_find #(
    parameter int HALF = 64,
    parameter int PW   = 6
) (
    input  logic [HALF-1:0] sel_i,
    input  logic [PW:0]     from_i,
    output logic            hit_o,
    output logic [PW-1:0]   idx_o
);
    always_comb begin
        hit_o = 1'b0;
        idx_o = '0;
        for (int i = 0; i < HALF; i++) begin
            if (!hit_o && sel_i[i] && ((PW+1)'(i) >= from_i)) begin
                hit_o = 1'b1;
                idx_o = PW'(i);
            end
        end
    end
endmodule

// File: rtl/rs_col_ser.sv
module rs_col_ser #(
    parameter int WBITS = 10
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             load_i,
    input  logic             shift_i,
    input  logic             en_i,
    input  logic [WBITS-1:0] word_i,
    output logic             bit_o
);
    logic [WBITS-1:0] sr_d, sr_q;

    always_comb begin
        sr_d = sr_q;
        if (load_i)       sr_d = en_i ? word_i : '0;
        else if (shift_i) sr_d = {sr_q[WBITS-2:0], 1'b0};
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) sr_q <= '0;
        else         sr_q <= sr_d;
    end

    assign bit_o = sr_q[WBITS-1];
endmodule

// File: rtl/rs_readout_seq.sv
module rs_readout_seq #(
    parameter int NCOLS = 160,
    parameter int NROWS = 128,
    parameter int WBITS = 10,
    parameter int MW    = 16,
    localparam int HALF   = NROWS / 2,
    localparam int PW     = $clog2(HALF),
    localparam int BW     = $clog2(WBITS),
    localparam int RW     = $clog2(NROWS),
    localparam int RWORDS = (NROWS + MW - 1) / MW,
    localparam int CWORDS = (NCOLS + MW - 1) / MW,
    localparam int MAXW   = (RWORDS > CWORDS) ? RWORDS : CWORDS,
    localparam int IW     = (MAXW > 1) ? $clog2(MAXW) : 1
) (
    input  logic                   clk_i,
    input  logic                   rst_ni,
    input  logic                   frame_start_i,
    output logic                   frame_done_o,
    input  logic                   cfg_wr_i,
    input  logic                   cfg_col_i,
    input  logic [IW-1:0]          cfg_idx_i,
    input  logic [MW-1:0]          cfg_data_i,
    output logic [RW-1:0]          row_up_o,
    output logic [RW-1:0]          row_dn_o,
    input  logic [NCOLS*WBITS-1:0] pix_up_i,
    input  logic [NCOLS*WBITS-1:0] pix_dn_i,
    output logic [NCOLS-1:0]       ser_up_o,
    output logic [NCOLS-1:0]       ser_dn_o,
    output logic                   wvld_up_o,
    output logic                   wvld_dn_o
);
    import rs_pkg::*;

    typedef struct packed {
        seq_st_e       st;
        logic [PW-1:0] nxt;
        logic          has_nxt;
        logic [BW-1:0] bitc;
        logic          done;
        logic          up_on;
        logic          dn_on;
    } seq_s;

    seq_s s_d, s_q;

    logic [NROWS-1:0] row_mask;
    logic [NCOLS-1:0] col_mask;
    logic [HALF-1:0]  pair_sel;
    logic [PW:0]      find_from;
    logic             find_hit;
    logic [PW-1:0]    find_idx;
    logic             busy;
    logic             run;
    logic             load;
    logic             shift;
    logic             last_bit;
    logic [NCOLS-1:0] raw_up, raw_dn;

    assign busy     = (s_q.st != ST_IDLE);
    assign run      = (s_q.st == ST_RUN);
    assign last_bit = (s_q.bitc == BW'(WBITS - 1));

    rs_mask_regs #(.NROWS(NROWS), .NCOLS(NCOLS), .MW(MW), .IW(IW)) u_masks (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .wr_i       (cfg_wr_i && !busy),
        .col_i      (cfg_col_i),
        .idx_i      (cfg_idx_i),
        .data_i     (cfg_data_i),
        .row_mask_o (row_mask),
        .col_mask_o (col_mask)
    );

    // A pair is kept when either of its rows is selected.
    for (genvar k = 0; k < HALF; k++) begin : g_pair
        assign pair_sel[k] = row_mask[HALF-1-k] | row_mask[HALF+k];
    end

    assign find_from = busy ? ({1'b0, s_q.nxt} + (PW+1)'(1)) : '0;

    rs_pair_find #(.HALF(HALF), .PW(PW)) u_find (
        .sel_i  (pair_sel),
        .from_i (find_from),
        .hit_o  (find_hit),
        .idx_o  (find_idx)
    );

    assign row_up_o = RW'(HALF - 1) - RW'(s_q.nxt);
    assign row_dn_o = RW'(HALF) + RW'(s_q.nxt);

    always_comb begin
        s_d      = s_q;
        s_d.done = 1'b0;
        load     = 1'b0;
        shift    = 1'b0;
        unique case (s_q.st)
            ST_IDLE: begin
                if (frame_start_i) begin
                    if (find_hit) begin
                        s_d.st  = ST_FILL;
                        s_d.nxt = find_idx;
                    end else begin
                        s_d.done = 1'b1;
                    end
                end
            end
            ST_FILL, ST_RUN: begin
                if (s_q.st == ST_FILL || last_bit) begin
                    if (s_q.st == ST_FILL || s_q.has_nxt) begin
                        load        = 1'b1;
                        s_d.st      = ST_RUN;
                        s_d.bitc    = '0;
                        s_d.up_on   = row_mask[row_up_o];
                        s_d.dn_on   = row_mask[row_dn_o];
                        s_d.nxt     = find_idx;
                        s_d.has_nxt = find_hit;
                    end else begin
                        s_d.st    = ST_IDLE;
                        s_d.done  = 1'b1;
                        s_d.up_on = 1'b0;
                        s_d.dn_on = 1'b0;
                    end
                end else begin
                    shift    = 1'b1;
                    s_d.bitc = s_q.bitc + BW'(1);
                end
            end
            default: s_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            s_q <= '{st: ST_IDLE, nxt: '0, has_nxt: 1'b0, bitc: '0,
                     done: 1'b0, up_on: 1'b0, dn_on: 1'b0};
        end else begin
            s_q <= s_d;
        end
    end

    for (genvar c = 0; c < NCOLS; c++) begin : g_col
        rs_col_ser #(.WBITS(WBITS)) u_up (
            .clk_i   (clk_i),
            .rst_ni  (rst_ni),
            .load_i  (load),
            .shift_i (shift),
            .en_i    (col_mask[c] & row_mask[row_up_o]),
            .word_i  (pix_up_i[c*WBITS +: WBITS]),
            .bit_o   (raw_up[c])
        );
        rs_col_ser #(.WBITS(WBITS)) u_dn (
            .clk_i   (clk_i),
            .rst_ni  (rst_ni),
            .load_i  (load),
            .shift_i (shift),
            .en_i    (col_mask[c] & row_mask[row_dn_o]),
            .word_i  (pix_dn_i[c*WBITS +: WBITS]),
            .bit_o   (raw_dn[c])
        );
    end

    assign ser_up_o     = run ? raw_up : '0;
    assign ser_dn_o     = run ? raw_dn : '0;
    assign wvld_up_o    = run && (s_q.bitc == '0) && s_q.up_on;
    assign wvld_dn_o    = run && (s_q.bitc == '0) && s_q.dn_on;
    assign frame_done_o = s_q.done;
endmodule

// File: rtl/rs_readout_chk.sv
module rs_readout_chk #(
    parameter int NCOLS = 160,
    parameter int NROWS = 128
) (
    input logic             clk_i,
    input logic             rst_ni,
    input logic             frame_done_o,
    input logic             wvld_up_o,
    input logic             wvld_dn_o,
    input logic [NCOLS-1:0] ser_up_o,
    input logic [NCOLS-1:0] ser_dn_o,
    input logic             busy,
    input logic             cfg_wr_i,
    input logic [NROWS-1:0] row_mask,
    input logic [NCOLS-1:0] col_mask
);
    // R8: done lasts a single cycle
    p_done_single_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        frame_done_o |=> !frame_done_o);

    // R7: word-valid only on the first bit of a word
    p_vld_first_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (wvld_up_o || wvld_dn_o) |=> !(wvld_up_o || wvld_dn_o));

    // R6: gated columns stay low
    p_col_gate_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ((ser_up_o | ser_dn_o) & ~col_mask) == '0);

    // R1: nothing is driven while idle
    p_idle_quiet_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !busy |-> (ser_up_o == '0 && ser_dn_o == '0 && !wvld_up_o && !wvld_dn_o));

    // R10: masks locked during a frame
    p_cfg_locked_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (busy && cfg_wr_i) |=> ($stable(row_mask) && $stable(col_mask)));
endmodule

bind rs_readout_seq rs_readout_chk #(.NCOLS(NCOLS), .NROWS(NROWS)) u_chk (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .frame_done_o (frame_done_o),
    .wvld_up_o    (wvld_up_o),
    .wvld_dn_o    (wvld_dn_o),
    .ser_up_o     (ser_up_o),
    .ser_dn_o     (ser_dn_o),
    .busy         (busy),
    .cfg_wr_i     (cfg_wr_i),
    .row_mask     (row_mask),
    .col_mask     (col_mask)
);

// File: tb/sim_rs_readout_seq.sv
module sim_rs_readout_seq;
    localparam int NC = 4;
    localparam int NR = 8;
    localparam int W  = 5;
    localparam int MW = 4;
    localparam int H  = NR / 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic done;
    logic cfg_wr = 1'b0;
    logic cfg_col = 1'b0;
    logic [0:0] cfg_idx = '0;
    logic [MW-1:0] cfg_data = '0;
    logic [2:0] row_up, row_dn;
    logic [NC*W-1:0] pix_up, pix_dn;
    logic [NC-1:0] ser_up, ser_dn;
    logic vld_up, vld_dn;

    int total = 0;
    int bad = 0;

    always #5 clk = ~clk;

    rs_readout_seq #(.NCOLS(NC), .NROWS(NR), .WBITS(W), .MW(MW)) u0 (
        .clk_i(clk), .rst_ni(rst_n), .frame_start_i(start), .frame_done_o(done),
        .cfg_wr_i(cfg_wr), .cfg_col_i(cfg_col), .cfg_idx_i(cfg_idx), .cfg_data_i(cfg_data),
        .row_up_o(row_up), .row_dn_o(row_dn), .pix_up_i(pix_up), .pix_dn_i(pix_dn),
        .ser_up_o(ser_up), .ser_dn_o(ser_dn), .wvld_up_o(vld_up), .wvld_dn_o(vld_dn)
    );

    function automatic logic [W-1:0] pixv(int row, int c);
        return W'((row * 5 + c * 11 + 3) % 32);
    endfunction

    // Array model: words follow the row selects.
    always_comb begin
        for (int c = 0; c < NC; c++) begin
            pix_up[c*W +: W] = pixv(int'(row_up), c);
            pix_dn[c*W +: W] = pixv(int'(row_dn), c);
        end
    end

    task automatic chk(input logic ok, input string tag, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
        end
    endtask

    task automatic cfg_write(input logic col, input logic [0:0] idx, input logic [MW-1:0] data);
        @(negedge clk);
        cfg_wr = 1'b1; cfg_col = col; cfg_idx = idx; cfg_data = data;
        @(negedge clk);
        cfg_wr = 1'b0;
    endtask

    // R10: row word 0 = rows 0..3, word 1 = rows 4..7; column word 0 = columns 0..3
    task automatic set_masks(input logic [7:0] rm, input logic [3:0] cm);
        cfg_write(1'b0, 1'b0, rm[3:0]);
        cfg_write(1'b0, 1'b1, rm[7:4]);
        cfg_write(1'b1, 1'b0, cm);
    endtask

    function automatic logic pair_on(logic [7:0] rm, int k);
        return rm[H-1-k] | rm[H+k];
    endfunction

    task automatic run_frame(input logic [7:0] rm, input logic [3:0] cm, input logic inj);
        int first;
        first = -1;
        for (int k = H - 1; k >= 0; k--) if (pair_on(rm, k)) first = k;
        @(negedge clk);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        if (first < 0) begin
            chk(done === 1'b1, "R8 empty-mask done", int'(done), 1);
            @(negedge clk);
            chk(done === 1'b0, "R8 empty-mask single", int'(done), 0);
            return;
        end
        // fill cycle
        chk(ser_up === '0 && ser_dn === '0 && !done, "R4 fill idle", int'(ser_up), 0);
        chk(int'(row_up) == H - 1 - first && int'(row_dn) == H + first, "R3 first pair",
            int'(row_up), H - 1 - first);
        for (int k = 0; k < H; k++) begin
            if (!pair_on(rm, k)) continue;
            for (int b = 0; b < W; b++) begin
                logic [NC-1:0] eu, ed;
                int nk;
                @(negedge clk);
                start = 1'b0;
                cfg_wr = 1'b0;
                for (int c = 0; c < NC; c++) begin
                    logic [W-1:0] wu, wd;
                    wu = pixv(H - 1 - k, c);
                    wd = pixv(H + k, c);
                    eu[c] = rm[H-1-k] & cm[c] & wu[W-1-b];
                    ed[c] = rm[H+k] & cm[c] & wd[W-1-b];
                end
                chk(ser_up === eu, "R2 R5 R6 upper bits", int'(ser_up), int'(eu));
                chk(ser_dn === ed, "R2 R5 R6 lower bits", int'(ser_dn), int'(ed));
                chk(vld_up === ((b == 0) && rm[H-1-k]), "R7 upper valid", int'(vld_up), int'((b == 0) && rm[H-1-k]));
                chk(vld_dn === ((b == 0) && rm[H+k]), "R7 lower valid", int'(vld_dn), int'((b == 0) && rm[H+k]));
                chk(done === 1'b0, "R8 no early done", int'(done), 0);
                if (b == W - 1) begin
                    nk = -1;
                    for (int j = H - 1; j > k; j--) if (pair_on(rm, j)) nk = j;
                    if (nk >= 0)
                        chk(int'(row_up) == H - 1 - nk && int'(row_dn) == H + nk, "R3 next pair",
                            int'(row_up), H - 1 - nk);
                end
                if (inj && b == 1) begin
                    // R9 and R10 stimulus inside a frame
                    start = 1'b1;
                    cfg_wr = 1'b1; cfg_col = 1'b0; cfg_idx = 1'b0; cfg_data = '0;
                end
            end
        end
        @(negedge clk);
        chk(done === 1'b1, "R8 R4 done after last bit", int'(done), 1);
        chk(ser_up === '0 && ser_dn === '0, "R9 no restart", int'(ser_up), 0);
        @(negedge clk);
        chk(done === 1'b0, "R8 done single", int'(done), 0);
        chk(ser_up === '0 && !vld_up, "R9 stays idle", int'(ser_up), 0);
    endtask

    // {row mask, column mask}
    localparam logic [11:0] VEC [4] = '{
        {8'hFF, 4'hF},
        {8'b1000_0001, 4'b0101},
        {8'b0001_0100, 4'b1010},
        {8'b0010_1000, 4'b0000}
    };

    initial begin
        #500_000;
        bad++;
        total++;
        $display("FAIL watchdog act=0 exp=1");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        chk(ser_up === '0 && ser_dn === '0, "R1 serial low", int'(ser_up), 0);
        chk(!done && !vld_up && !vld_dn, "R1 strobes low", int'(done), 0);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 default masks: full frame without any write
        run_frame(8'hFF, 4'hF, 1'b0);

        for (int v = 0; v < 4; v++) begin
            set_masks(VEC[v][11:4], VEC[v][3:0]);
            run_frame(VEC[v][11:4], VEC[v][3:0], 1'b0);
        end

        // R9 / R10: start and mask write during a frame are ignored
        set_masks(8'hFF, 4'hF);
        run_frame(8'hFF, 4'hF, 1'b1);
        run_frame(8'hFF, 4'hF, 1'b0);

        // R10: upper word alone, rows 4..7 only
        cfg_write(1'b0, 1'b0, 4'h0);
        run_frame(8'hF0, 4'hF, 1'b0);

        // R8: no rows selected
        cfg_write(1'b0, 1'b1, 4'h0);
        run_frame(8'h00, 4'hF, 1'b0);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule